// File: doc/BRIEF.md
# SDRAM Periodic Refresh Scheduler

This block keeps an SDR SDRAM alive on behalf of a memory controller. A free-running interval timer raises a refresh request once per refresh slot; the slot length is a parameter chosen so that 4096 refreshes fit inside each 64 ms retention window. At 100 MHz that is 1562 clocks. The request stays up until the controller's access path hands the command bus over with a grant.

Once it holds the bus, the scheduler closes every bank with a precharge-all command. It waits the row precharge time and then issues an auto-refresh. It keeps the bus for the refresh cycle time, driving NOP on every wait cycle. Minimum times are given in picoseconds and turned into whole clocks by rounding up.

If a second slot expires while a request is still waiting, the scheduler records an overrun. The next granted sequence then issues two auto-refreshes, one refresh cycle time apart, before it gives the bus back.

Top module: `sdram_refresh_sched`

## Requirements
- R1: After reset is released, `ref_req` first rises after exactly `INTERVAL_CLKS` rising clock edges, and a new slot expires every `INTERVAL_CLKS` clocks after that.
- R2: `ref_req` stays high until a clock edge where it is high, `ref_gnt` is high and the block is idle. The sequence starts at that edge and `busy` is high from the next cycle on. `ref_req` drops then, unless a slot expires at the same edge.
- R3: When a slot expires while `ref_req` is still pending and not being granted, `overrun` goes high and stays high until the next grant. It clears on that grant, and that sequence issues two auto-refresh commands.
- R4: In the first cycle after a grant, the bus carries precharge-all: cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1.
- R5: Auto-refresh (cs_n=0, ras_n=0, cas_n=0, we_n=1, a10=0, cke=1) follows precharge-all after T_RP clocks, where T_RP = ceil(T_RP_PS / CLK_PERIOD_PS).
- R6: After each auto-refresh the block keeps `busy` high and issues no other command for T_RFC clocks, where T_RFC = ceil(T_RFC_PS / CLK_PERIOD_PS). In a double sequence, the second auto-refresh comes exactly T_RFC clocks after the first. `busy` falls T_RFC clocks after the last one.
- R7: Every cycle that is neither precharge-all nor auto-refresh drives NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1, a10=0), and `cke` is always 1.
- R8: `ref_gnt` while `ref_req` is low has no effect: `busy` stays low, the bus stays NOP, and the slot timer is not disturbed.
- R9: During and right after reset, `ref_req`, `overrun` and `busy` are 0 and the bus carries NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_gnt | input | 1 | Bus grant from the access path |
| ref_req | output | 1 | Refresh request to the access path |
| busy | output | 1 | Scheduler owns the command bus |
| overrun | output | 1 | A refresh slot was missed; a double refresh is pending |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_a10 | output | 1 | Address bit 10, selects all banks for precharge |

## Verification
The request is due `INTERVAL_CLKS` edges after reset. Precharge-all appears in the cycle after the granting edge, auto-refresh T_RP cycles later, a second auto-refresh T_RFC cycles after the first when an overrun was pending, and `busy` falls T_RFC cycles after the last refresh. The bench counts edges from the granting edge and samples each output on the falling edge of the cycle in which it is due, so every register on the path is already counted. Grant delays of one slot minus one and of exactly one slot probe the edge where a slot expiry meets a grant.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PALL = 2'd1,
    CMD_AREF = 2'd2
  } rfsh_cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic a10;
  } sd_pins_t;

  // whole clocks covering a minimum time, rounded up
  function automatic int clk_ceil(input int t_ps, input int period_ps);
    return (t_ps + period_ps - 1) / period_ps;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic sd_pins_t encode_cmd(input rfsh_cmd_e c);
    sd_pins_t p;
    case (c)
      CMD_PALL: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
      CMD_AREF: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
      default:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int INTERVAL_CLKS = 1562
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = $clog2(INTERVAL_CLKS + 1);
  localparam logic [CW-1:0] RELOAD = CW'(INTERVAL_CLKS - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= RELOAD;
    else if (tick) cnt_q <= RELOAD;
    else           cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/rfsh_pending.sv
module rfsh_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic gnt,
  input  logic idle,
  output logic req,
  output logic ovr,
  output logic take
);
  logic req_q, ovr_q;

  assign take = req_q & gnt & idle;
  assign req  = req_q;
  assign ovr  = ovr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (tick)      req_q <= 1'b1;
      else if (take) req_q <= 1'b0;

      if (take)               ovr_q <= 1'b0;
      else if (tick && req_q) ovr_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rfsh_seq_fsm.sv
module rfsh_seq_fsm
  import rfsh_pkg::*;
#(
  parameter int T_RP  = 3,
  parameter int T_RFC = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      take,
  input  logic      double_ref,
  output logic      idle,
  output rfsh_cmd_e cmd
);
  localparam int WMAX = max2(T_RP, T_RFC);
  localparam int WW   = $clog2(WMAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_RP, S_REF, S_RFC
  } state_e;

  state_e        st_q, st_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          second_q, second_d;

  assign idle = (st_q == S_IDLE);

  always_comb begin
    case (st_q)
      S_PRE:   cmd = CMD_PALL;
      S_REF:   cmd = CMD_AREF;
      default: cmd = CMD_NOP;
    endcase
  end

  always_comb begin
    st_d     = st_q;
    wcnt_d   = wcnt_q;
    second_d = second_q;
    case (st_q)
      S_IDLE: if (take) begin
        st_d     = S_PRE;
        second_d = double_ref;
      end
      S_PRE: begin
        if (T_RP > 1) begin
          st_d   = S_RP;
          wcnt_d = WW'(T_RP - 2);
        end else begin
          st_d = S_REF;
        end
      end
      S_RP: begin
        if (wcnt_q == '0) st_d = S_REF;
        else              wcnt_d = wcnt_q - 1'b1;
      end
      S_REF: begin
        if (T_RFC > 1) begin
          st_d   = S_RFC;
          wcnt_d = WW'(T_RFC - 2);
        end else if (second_q) begin
          st_d     = S_REF;
          second_d = 1'b0;
        end else begin
          st_d = S_IDLE;
        end
      end
      S_RFC: begin
        if (wcnt_q != '0) begin
          wcnt_d = wcnt_q - 1'b1;
        end else if (second_q) begin
          st_d     = S_REF;
          second_d = 1'b0;
        end else begin
          st_d = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      wcnt_q   <= '0;
      second_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      wcnt_q   <= wcnt_d;
      second_q <= second_d;
    end
  end
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import rfsh_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 10000,
  parameter int T_RP_PS       = 24000,
  parameter int T_RFC_PS      = 80000,
  parameter int INTERVAL_CLKS = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic busy,
  output logic overrun,
  output logic sd_cke,
  output logic sd_cs_n,
  output logic sd_ras_n,
  output logic sd_cas_n,
  output logic sd_we_n,
  output logic sd_a10
);
  localparam int T_RP  = clk_ceil(T_RP_PS, CLK_PERIOD_PS);
  localparam int T_RFC = clk_ceil(T_RFC_PS, CLK_PERIOD_PS);

  // named internal events, observed by the bound checker
  logic      slot_tick;
  logic      grant_take;
  logic      seq_idle;
  logic      pre_evt;
  logic      ref_evt;
  rfsh_cmd_e cur_cmd;
  sd_pins_t  pins;

  rfsh_interval_timer #(.INTERVAL_CLKS(INTERVAL_CLKS)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (slot_tick)
  );

  rfsh_pending u_pend (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (slot_tick),
    .gnt  (ref_gnt),
    .idle (seq_idle),
    .req  (ref_req),
    .ovr  (overrun),
    .take (grant_take)
  );

  rfsh_seq_fsm #(.T_RP(T_RP), .T_RFC(T_RFC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (grant_take),
    .double_ref(overrun),
    .idle      (seq_idle),
    .cmd       (cur_cmd)
  );

  assign pre_evt  = (cur_cmd == CMD_PALL);
  assign ref_evt  = (cur_cmd == CMD_AREF);
  assign pins     = encode_cmd(cur_cmd);
  assign busy     = ~seq_idle;
  assign sd_cke   = 1'b1;
  assign sd_cs_n  = pins.cs_n;
  assign sd_ras_n = pins.ras_n;
  assign sd_cas_n = pins.cas_n;
  assign sd_we_n  = pins.we_n;
  assign sd_a10   = pins.a10;
endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk #(
  parameter int T_RP  = 3,
  parameter int T_RFC = 8
) (
  input logic clk,
  input logic rst_n,
  input logic slot_tick,
  input logic grant_take,
  input logic ref_req,
  input logic overrun,
  input logic busy,
  input logic pre_evt,
  input logic ref_evt,
  input logic sd_cs_n,
  input logic sd_ras_n,
  input logic sd_cas_n,
  input logic sd_we_n
);
  localparam int SAT = 65535;
  int since_pre, since_ref;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_pre <= SAT;
      since_ref <= SAT;
    end else begin
      since_pre <= pre_evt ? 1 : ((since_pre < SAT) ? since_pre + 1 : SAT);
      since_ref <= ref_evt ? 1 : ((since_ref < SAT) ? since_ref + 1 : SAT);
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req && !grant_take |=> ref_req); // R2

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick && ref_req && !grant_take |=> overrun); // R3

  AST_OVR_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> ref_req); // R3

  AST_PRE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    grant_take |=> pre_evt && busy); // R4

  AST_RP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ref_evt |-> since_pre >= T_RP && since_pre < SAT); // R5

  AST_RFC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_evt || ref_evt) |-> since_ref >= T_RFC); // R6

  AST_BUSY_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_evt && !ref_evt |-> !sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n); // R7

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pre_evt, ref_evt})); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pre_evt && !ref_evt); // R8
endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(.T_RP(T_RP), .T_RFC(T_RFC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .slot_tick (slot_tick),
  .grant_take(grant_take),
  .ref_req   (ref_req),
  .overrun   (overrun),
  .busy      (busy),
  .pre_evt   (pre_evt),
  .ref_evt   (ref_evt),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n)
);

// File: tb/sdram_refresh_sched_tb.sv
module sdram_refresh_sched_tb;
  // 200 MHz bench clock; DUT timing given for a 5 ns period
  localparam int PER_PS = 5000;
  localparam int IVL    = 60;
  localparam int XRP    = 5;   // 24 ns / 5 ns rounded up
  localparam int XRFC   = 16;  // 80 ns / 5 ns
  localparam int NV     = 6;
  localparam int GDLY [NV] = '{0, 3, 20, IVL - 1, IVL, IVL + 5};
  localparam int EREFS[NV] = '{1, 1, 1, 1, 2, 2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt = 1'b0;
  logic ref_req, busy, overrun, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2500ps clk = ~clk;

  sdram_refresh_sched #(
    .CLK_PERIOD_PS(PER_PS), .T_RP_PS(24000), .T_RFC_PS(80000), .INTERVAL_CLKS(IVL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req), .busy(busy),
    .overrun(overrun), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_a10(sd_a10)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // bus as {cke, cs_n, ras_n, cas_n, we_n, a10}
  function automatic logic [5:0] bus();
    return {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10};
  endfunction
  localparam logic [5:0] B_NOP  = 6'b101110;
  localparam logic [5:0] B_PALL = 6'b100101;
  localparam logic [5:0] B_AREF = 6'b100010;

  task automatic do_reset();
    rst_n = 1'b0;
    ref_gnt = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 req", ref_req, 0);
    chk("R9 busy", busy, 0);
    chk("R9 overrun", overrun, 0);
    chk("R9 bus", bus(), B_NOP);
    rst_n = 1'b1;
  endtask

  // counts edges from reset release to ref_req
  task automatic wait_first_req(input int hold_gnt);
    int n = 0;
    while (!ref_req && n < 4 * IVL) begin
      ref_gnt = (n < hold_gnt);
      @(negedge clk);
      n++;
      if (n <= hold_gnt) begin
        chk("R8 busy", busy, 0);
        chk("R8 bus", bus(), B_NOP);
      end
    end
    ref_gnt = 1'b0;
    chk("R1 first req edges", n, IVL);
  endtask

  task automatic run_vec(input int d, input int nref);
    int last;
    int refs = 0;
    repeat (d) @(negedge clk);
    chk("R3 overrun before grant", overrun, (d >= IVL) ? 1 : 0);
    chk("R2 req pending", ref_req, 1);
    ref_gnt = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ref_gnt = 1'b0;
    last = XRP + nref * XRFC;
    for (int c = 0; c <= last; c++) begin
      logic [5:0] e;
      if (c == 0) begin
        chk("R2 req after grant", ref_req, (d == IVL - 1) ? 1 : 0);
        chk("R3 overrun cleared", overrun, 0);
      end
      if (c == 0) e = B_PALL;
      else if (c >= XRP && c < last && ((c - XRP) % XRFC) == 0) e = B_AREF;
      else e = B_NOP;
      if (c == 0) chk("R4 precharge-all", bus(), e);
      else if (e == B_AREF) chk("R5 auto-refresh", bus(), e);
      else chk("R7 wait nop", bus(), e);
      if (bus() == B_AREF) refs++;
      chk("R6 busy window", busy, (c < last) ? 1 : 0);
      if (c < last) @(negedge clk);
    end
    chk("R3 refresh count", refs, nref);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // table walk: each vector starts from reset
    for (int v = 0; v < NV; v++) begin
      do_reset();
      wait_first_req(0);
      run_vec(GDLY[v], EREFS[v]);
    end
    // R8: grant without a request, timer undisturbed
    do_reset();
    wait_first_req(12);
    run_vec(1, 1);
    // R1: slot period after a fast grant
    begin
      int n = 0;
      while (ref_req) @(negedge clk);
      while (!ref_req && n < 4 * IVL) begin @(negedge clk); n++; end
      // first req at IVL, grant at IVL+2, sequence ended XRP+XRFC later
      chk("R1 slot period", n, IVL - (2 + XRP + XRFC) - 1 + 1);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule